// File: doc/BRIEF.md
# Asynchronous Static Memory Strobe Controller

This block turns single host transfers into timed cycles on an asynchronous static memory or peripheral. After a request is taken, the controller drives chip select, byte enables, address and output enable. It then walks three phases: setup, strobe and hold. During the strobe phase the active-low read or write strobe is held low. Reads and writes each have their own three phase lengths, given in clock cycles and kept in a six-field configuration set.

A slow device can lengthen the strobe through a ready pin. The pin passes through a two-flop synchronizer. The controller looks at it only during the last two cycles of the programmed strobe. Once ready has been seen low, the strobe ends two cycles after ready is first seen high again. Read data is captured on the edge where the read strobe rises. The host gets a one-cycle acknowledge in the last hold cycle, together with the captured data.

The controller has six named states:
- `ST_IDLE` moves to `ST_SETUP` when a request is accepted.
- `ST_SETUP` moves to `ST_STROBE` when its count runs out.
- `ST_STROBE` moves to `ST_STRETCH` if ready is low inside the window, or to `ST_HOLD` when its count runs out.
- `ST_STRETCH` moves to `ST_TAIL` once ready is seen high.
- `ST_TAIL` moves to `ST_HOLD` after one cycle.
- `ST_HOLD` returns to `ST_IDLE` with the acknowledge.

Top module: `async_strobe_ctrl`

## Requirements
- R1: During and after reset, and whenever idle, mem_cs_n, mem_oe_n, mem_rd_n and mem_wr_n are high, mem_be_n is all ones, mem_wdata_oe is low and host_rdy is high.
- R2: Before the strobe falls, chip select is low with both strobes high for exactly S cycles. S is the effective setup count of the access direction.
- R3: If ready is high throughout, the strobe stays low for exactly T cycles, where T is the effective strobe count.
- R4: After the strobe rises, chip select stays low with both strobes high for exactly H cycles, the effective hold count, and then goes high.
- R5: A programmed count of zero acts as one cycle. Any other value v acts as v cycles.
- R6: For the whole access, the following stay constant:
  - mem_addr equals the request address.
  - mem_be_n equals the inverted host byte enables, where bit i enables data bits 8i+7..8i.
  - mem_oe_n is low for reads and high for writes.
  - mem_wdata_oe is high with mem_wdata equal to the write data for writes, and low for reads.
- R7: mem_rdy passes through two synchronizer flops. A low level that is no longer seen, after synchronization, by the last two programmed strobe cycles has no effect on the strobe length.
- R8: If the synchronized ready is low in one of the last two programmed strobe cycles, the strobe is extended. Suppose mem_rdy is raised during strobe cycle j, counting from 0. The strobe then lasts j+4 cycles whenever j+1 is at least max(T-2,0).
- R9: For a read, host_rdata takes the value mem_rdata had in the last cycle the read strobe was low.
- R10: host_ack is high for exactly one cycle per access, in the last hold cycle. For reads, host_rdata is valid in that cycle.
- R11: host_rdy is low for the whole access. A request is taken only while idle.
- R12: A configuration write with cfg_we high stores cfg_val into the field selected by cfg_idx. The field map is:
  - 0: read setup
  - 1: read strobe
  - 2: read hold
  - 3: write setup
  - 4: write strobe
  - 5: write hold

  The counts in use are taken when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration field write strobe |
| cfg_idx | input | 3 | Configuration field select |
| cfg_val | input | CNT_W | Phase count to store |
| host_req | input | 1 | Host transfer request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Transfer address |
| host_be | input | DATA_W/8 | Byte enables, active high |
| host_wdata | input | DATA_W | Write data |
| host_rdy | output | 1 | Controller idle and able to take a request |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_be_n | output | DATA_W/8 | Byte enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_oe_n | output | 1 | Output enable for reads, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wdata | output | DATA_W | Write data toward the pads |
| mem_wdata_oe | output | 1 | Drive enable for mem_wdata |
| mem_rdata | input | DATA_W | Read data from the memory |
| mem_rdy | input | 1 | Asynchronous ready, low stretches the strobe |

## Verification
The sharpest coincidence is between the strobe counter running out and the synchronized ready going low at the same moment. It is the boundary where a low ready either lands in the sampling window and stretches the strobe, or falls just before the window and is ignored. The bench provokes it with a six-cycle strobe and ready raised in cycles 1, 2 and 3. It does the same with single-cycle strobes, where the window opens in the first strobe cycle. Each resulting strobe width is compared against a bench function of the programmed count and the cycle in which ready was raised. Random transfers with random phase counts, including zero, and random release points then cover the same boundary across both directions.

// File: rtl/strb_pkg.sv
package strb_pkg;

    localparam int FIELDS = 6;

    localparam logic [2:0] F_RD_SETUP  = 3'd0;
    localparam logic [2:0] F_RD_STROBE = 3'd1;
    localparam logic [2:0] F_RD_HOLD   = 3'd2;
    localparam logic [2:0] F_WR_SETUP  = 3'd3;
    localparam logic [2:0] F_WR_STROBE = 3'd4;
    localparam logic [2:0] F_WR_HOLD   = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_STRETCH,
        ST_TAIL,
        ST_HOLD
    } strb_state_e;

endpackage

// File: rtl/strb_rdy_sync.sv
module strb_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

    // two-flop delay from the pin to the controller
    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_out == $past(chain_q[STAGES-2])));

endmodule

// File: rtl/strb_cfg_regs.sv
module strb_cfg_regs
    import strb_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int RESET_CNT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_idx,
    input  logic [CNT_W-1:0] cfg_val,
    output logic [CNT_W-1:0] rd_setup,
    output logic [CNT_W-1:0] rd_strobe,
    output logic [CNT_W-1:0] rd_hold,
    output logic [CNT_W-1:0] wr_setup,
    output logic [CNT_W-1:0] wr_strobe,
    output logic [CNT_W-1:0] wr_hold
);

    logic [CNT_W-1:0] fld_q [FIELDS];

    generate
        for (genvar g = 0; g < FIELDS; g++) begin : g_field
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fld_q[g] <= CNT_W'(RESET_CNT);
                else if (cfg_we && (cfg_idx == 3'(g)))
                    fld_q[g] <= cfg_val;
            end

            assert_cfg_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && (cfg_idx == 3'(g))) |=> (fld_q[g] == $past(cfg_val)));
        end
    endgenerate

    assign rd_setup  = fld_q[F_RD_SETUP];
    assign rd_strobe = fld_q[F_RD_STROBE];
    assign rd_hold   = fld_q[F_RD_HOLD];
    assign wr_setup  = fld_q[F_WR_SETUP];
    assign wr_strobe = fld_q[F_WR_STROBE];
    assign wr_hold   = fld_q[F_WR_HOLD];

endmodule

// File: rtl/strb_phase_timer.sv
module strb_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero,
    output logic             cnt_window
);

    logic [CNT_W-1:0] cnt_q;

    // a phase of v cycles counts v-1 down to 0; zero is raised to one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_zero   = (cnt_q == '0);
    assign cnt_window = (cnt_q <= CNT_W'(1));

    assert_zero_is_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val <= CNT_W'(1))) |=> cnt_zero);

endmodule

// File: rtl/async_strobe_ctrl.sv
module async_strobe_ctrl
    import strb_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_CNT   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_idx,
    input  logic [CNT_W-1:0]      cfg_val,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [DATA_W/8-1:0]   host_be,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic                  host_rdy,
    output logic                  host_ack,
    output logic [DATA_W-1:0]     host_rdata,
    output logic                  mem_cs_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_oe_n,
    output logic                  mem_rd_n,
    output logic                  mem_wr_n,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  mem_wdata_oe,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  mem_rdy
);

    localparam int BE_W = DATA_W / 8;

    strb_state_e      state_q, state_d;
    logic             rdy_s;
    logic             tmr_load, tmr_zero, tmr_window;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, capture, ready_hold_off;

    logic [CNT_W-1:0] c_rd_setup, c_rd_strobe, c_rd_hold;
    logic [CNT_W-1:0] c_wr_setup, c_wr_strobe, c_wr_hold;

    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [CNT_W-1:0]  strobe_q, hold_q;

    strb_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mem_rdy),
        .sync_out (rdy_s)
    );

    strb_cfg_regs #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_val   (cfg_val),
        .rd_setup  (c_rd_setup),
        .rd_strobe (c_rd_strobe),
        .rd_hold   (c_rd_hold),
        .wr_setup  (c_wr_setup),
        .wr_strobe (c_wr_strobe),
        .wr_hold   (c_wr_hold)
    );

    strb_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .load_val   (tmr_val),
        .cnt_zero   (tmr_zero),
        .cnt_window (tmr_window)
    );

    assign accept         = (state_q == ST_IDLE) && host_req;
    assign ready_hold_off = tmr_window && !rdy_s;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and phase timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = host_we ? c_wr_setup : c_rd_setup;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = strobe_q;
                end
            end
            ST_STROBE: begin
                if (ready_hold_off) begin
                    state_d = ST_STRETCH;
                end else if (tmr_zero) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = hold_q;
                end
            end
            ST_STRETCH: begin
                if (rdy_s) state_d = ST_TAIL;
            end
            ST_TAIL: begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = hold_q;
            end
            ST_HOLD: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign capture = !we_q && (((state_q == ST_STROBE) && (state_d == ST_HOLD)) ||
                               (state_q == ST_TAIL));

    // request, count snapshot and read capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            addr_q   <= '0;
            be_q     <= '0;
            wdata_q  <= '0;
            strobe_q <= '0;
            hold_q   <= '0;
            rdata_q  <= '0;
        end else begin
            if (accept) begin
                we_q     <= host_we;
                addr_q   <= host_addr;
                be_q     <= host_be;
                wdata_q  <= host_wdata;
                strobe_q <= host_we ? c_wr_strobe : c_rd_strobe;
                hold_q   <= host_we ? c_wr_hold   : c_rd_hold;
            end
            if (capture) rdata_q <= mem_rdata;
        end
    end

    // output decode
    logic in_access, in_strobe;
    always_comb begin
        in_access = (state_q != ST_IDLE);
        in_strobe = (state_q == ST_STROBE) || (state_q == ST_STRETCH) ||
                    (state_q == ST_TAIL);
        mem_cs_n     = !in_access;
        mem_be_n     = in_access ? ~be_q : '1;
        mem_addr     = addr_q;
        mem_oe_n     = !(in_access && !we_q);
        mem_rd_n     = !(in_strobe && !we_q);
        mem_wr_n     = !(in_strobe && we_q);
        mem_wdata    = wdata_q;
        mem_wdata_oe = in_access && we_q;
        host_rdy     = !in_access;
        host_ack     = (state_q == ST_HOLD) && tmr_zero;
        host_rdata   = rdata_q;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |-> (mem_rd_n && mem_wr_n && mem_cs_n && !mem_wdata_oe));

    assert_setup_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_rd_n) || $fell(mem_wr_n)) |-> $past(!mem_cs_n));

    assert_hold_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd_n) || $rose(mem_wr_n)) |-> !mem_cs_n);

    assert_select_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |->
            ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_oe_n)));

    assert_stretch_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STRETCH) && rdy_s) |=> (state_q == ST_TAIL) ##1 (state_q == ST_HOLD));

    assert_rdata_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |-> (host_rdata == $past(mem_rdata)));

    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> (!host_ack && host_rdy));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !host_rdy);

endmodule

// File: tb/async_strobe_ctrl_tb_top.sv
module async_strobe_ctrl_tb_top;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 4;
    localparam int BE_W   = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_idx = '0;
    logic [CNT_W-1:0]  cfg_val = '0;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [BE_W-1:0]   host_be = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              host_rdy, host_ack;
    logic [DATA_W-1:0] host_rdata;
    logic              mem_cs_n, mem_oe_n, mem_rd_n, mem_wr_n, mem_wdata_oe;
    logic [BE_W-1:0]   mem_be_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_rdy = 1'b1;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int cfg_sh [6];

    always #4 clk = ~clk;

    async_strobe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_be(host_be), .host_wdata(host_wdata),
        .host_rdy(host_rdy), .host_ack(host_ack), .host_rdata(host_rdata),
        .mem_cs_n(mem_cs_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_oe_n(mem_oe_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // expected strobe width: ready raised in strobe cycle j (j<0: never low)
    function automatic int strobe_len(input int t, input int j);
        int w;
        w = (t > 2) ? t - 2 : 0;
        if (j >= 0 && (j + 1) >= w) return j + 4;
        return t;
    endfunction

    task automatic cfg_write(input int idx, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_val = CNT_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_sh[idx] = val;
    endtask

    task automatic run_access(input bit we, input int j, input logic [ADDR_W-1:0] a,
                              input logic [BE_W-1:0] be, input logic [DATA_W-1:0] wd,
                              input logic [DATA_W-1:0] pat);
        int base, es, et, eh;
        int n_set, n_str, n_hld, n_ack, ack_at, guard;
        bit sel_bad, busy_bad, seen_cs;
        logic [DATA_W-1:0] last_rd, got;
        base = we ? 3 : 0;
        es = eff(cfg_sh[base]);
        et = strobe_len(eff(cfg_sh[base+1]), j);
        eh = eff(cfg_sh[base+2]);
        n_set = 0; n_str = 0; n_hld = 0; n_ack = 0; ack_at = -1; guard = 0;
        sel_bad = 0; busy_bad = 0; seen_cs = 0; last_rd = '0; got = '0;
        @(negedge clk);
        if (j >= 0) begin
            mem_rdy = 1'b0;
            repeat (3) @(negedge clk);
        end
        host_req = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        while (guard < 200) begin
            guard++;
            if (mem_cs_n) begin
                if (seen_cs) break;
            end else begin
                seen_cs = 1;
                if (host_rdy) busy_bad = 1;
                if (mem_addr !== a || mem_be_n !== ~be || mem_oe_n !== we ||
                    mem_wdata_oe !== we || (we && mem_wdata !== wd)) sel_bad = 1;
                if (!mem_rd_n || !mem_wr_n) begin
                    if (n_str == j) mem_rdy = 1'b1;
                    mem_rdata = pat ^ DATA_W'(n_str);
                    last_rd = mem_rdata;
                    n_str++;
                end else if (n_str == 0) begin
                    n_set++;
                end else begin
                    n_hld++;
                    if (host_ack) begin
                        n_ack++; ack_at = n_hld; got = host_rdata;
                    end
                end
            end
            @(negedge clk);
        end
        mem_rdy = 1'b1;
        chk("R2 setup cycles", n_set, es);
        if (j < 0) chk("R3 strobe cycles", n_str, et);
        else       chk("R8 stretched strobe cycles", n_str, et);
        chk("R4 hold cycles", n_hld, eh);
        chk("R10 ack count", n_ack, 1);
        chk("R10 ack in last hold cycle", ack_at, eh);
        chk("R6 select/data stable", sel_bad, 0);
        chk("R11 busy during access", busy_bad, 0);
        if (!we) chk("R9 read data", got, last_rd);
        chk("R11 idle again", host_rdy, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                tests++; fails++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 6; i++) cfg_sh[i] = 2;
        repeat (3) @(negedge clk);
        chk("R1 reset cs_n", mem_cs_n, 1);
        chk("R1 reset strobes", {mem_rd_n, mem_wr_n, mem_oe_n}, 3'b111);
        chk("R1 reset wdata_oe", mem_wdata_oe, 0);
        chk("R1 reset be_n", mem_be_n, {BE_W{1'b1}});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle host_rdy", host_rdy, 1);

        // R12 field map: distinct counts per field, read then write
        cfg_write(0, 3); cfg_write(1, 4); cfg_write(2, 1);
        cfg_write(3, 1); cfg_write(4, 2); cfg_write(5, 5);
        run_access(0, -1, 20'h12345, 4'b1111, 32'h0, 32'hA5A50000);
        run_access(1, -1, 20'h0ABCD, 4'b0101, 32'hDEADBEEF, 32'h0);

        // R5 zero counts
        for (int i = 0; i < 6; i++) cfg_write(i, 0);
        run_access(0, -1, 20'h00001, 4'b1000, 32'h0, 32'h11110000);
        run_access(1, -1, 20'h00002, 4'b0001, 32'h55AA55AA, 32'h0);
        run_access(0, 0, 20'h00003, 4'b1111, 32'h0, 32'h22220000);   // R8 single-cycle strobe

        // R7 window boundary with a six-cycle strobe
        cfg_write(1, 6);
        run_access(0, 1, 20'h00010, 4'b1111, 32'h0, 32'h33330000);   // R7 ignored
        run_access(0, 2, 20'h00011, 4'b1111, 32'h0, 32'h44440000);   // R7 ignored
        run_access(0, 3, 20'h00012, 4'b1111, 32'h0, 32'h55550000);   // R8 stretched
        run_access(0, 9, 20'h00013, 4'b1111, 32'h0, 32'h66660000);   // R8 long stretch

        // R1 no spurious access after idle
        repeat (4) begin
            @(negedge clk);
            chk("R1 stays idle", {mem_cs_n, host_rdy}, 2'b11);
        end

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < 6; i++) cfg_write(i, $urandom_range(0, 6));
            run_access(1'($urandom_range(0, 1)),
                       ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, 10)),
                       ADDR_W'($urandom), BE_W'($urandom), $urandom, $urandom);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule